// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Bus Snooping

This block is a small direct-mapped cache that sits between a processor access port and a byte-wide main memory port. The 6-bit byte address is split into a 2-bit tag (bits 5:4), a 2-bit line index (bits 3:2) and a 2-bit word offset (bits 1:0). There are four lines of four bytes each, so any memory block has exactly one line it can occupy. A read that hits returns its byte in the same cycle. A read that misses first loads the whole block from memory, one byte at a time, and then hands the requested byte to the processor.

Every processor write is sent to memory. A write that hits also updates the cached byte. A write that misses leaves the cache untouched. A snoop input carries the addresses written by other bus masters. When such an address falls in a block held by a valid line, that line is dropped. An address window, picked out by the top address bits (by default the top two bits equal to 2'b11, which is bytes 0x30 to 0x3F), is never cached. Every access in that window goes straight to memory as a single transfer.

The processor holds its request, address, write flag and write data steady while `cpu_stall` is high. The access completes on the first rising edge at which `cpu_stall` is low. Memory transfers use a request/acknowledge handshake. A transfer completes on an edge where both `mem_req` and `mem_ack` are high, and read data is valid together with `mem_ack`.

Top module: `dmc_snoop_wt_cache`

## Requirements
- R1: A cacheable read whose line is valid with a matching tag completes in the request cycle with `cpu_stall` low, returns the cached byte and makes no memory transfer.
- R2: A cacheable read miss makes exactly four memory reads, to offsets 0, 1, 2 and 3 of the block in that order, with `cpu_stall` high until the fill ends. It then returns the requested byte, and a following read to the same block hits.
- R3: A block whose line index matches a resident block with a different tag replaces that block. Going back to the earlier block misses again.
- R4: Every processor write makes exactly one memory write of its byte. If the write hits, the cached byte is updated too, and a later read hit returns the new value without a memory transfer.
- R5: A write miss does not allocate a line. A read of that block afterwards is a full four-transfer miss that returns the written value.
- R6: A snoop whose address falls in a block held by a valid line invalidates that line, so the next read of the block misses and returns the current memory contents. A snoop to a different tag has no effect on a resident line.
- R7: A snoop that names the block being filled, at any time during the fill, leaves the line invalid when the fill ends. The current access still completes.
- R8: Every access whose address bits 5:4 equal the noncacheable value (default 2'b11) makes exactly one memory transfer and never fills or hits a line.
- R9: Reset clears every valid bit. Out of reset with no request, `cpu_stall` and `mem_req` are low, and the first read of any block misses.
- R10: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_addr` and `mem_we` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid when the access completes |
| cpu_stall | output | 1 | High while the current request is not yet complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 6 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes on this edge |
| snoop_valid | input | 1 | Another master writes snoop_addr this cycle |
| snoop_addr | input | 6 | Address written by another master |

## Verification
The assertions check on every cycle that the memory handshake stays stable while it waits, and that a write always puts a memory write on the port in the next cycle. They also check that a hit completes with no memory request, that a fill never drives a write, that a noncacheable address never validates a line, that a matching snoop clears its line, and that reset empties the cache. The bench alone can show the rest. That covers returned data values and the exact count and order of fill transfers. It also covers conflict eviction, write-miss no-allocate, and the snoop that lands in the middle of a fill. Each of these is only visible over a sequence of accesses, compared against a reference memory kept in the bench.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SINGLE = 2'd2,
        ST_DONE   = 2'd3
    } state_e;

    function automatic addr_t split_addr(input logic [ADDR_W-1:0] a);
        return addr_t'(a);
    endfunction

    function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_byte,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              snp_en,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WORDS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_byte  = data_q[rd_idx][rd_off];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic set_here, drop_here;
        assign set_here  = set_en && (set_idx == IDX_W'(i));
        assign drop_here = (clr_en && (clr_idx == IDX_W'(i))) ||
                           (snp_en && (snp_idx == IDX_W'(i)) && (tag_q[i] == snp_tag));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (set_here) begin
                valid_q[i] <= 1'b1;
            end else if (drop_here) begin
                valid_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
            end else if (set_here) begin
                tag_q[i] <= set_tag;
            end
        end

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && (wr_idx == IDX_W'(i)) && (wr_off == OFF_W'(w))) begin
                    data_q[i][w] <= wr_data;
                end
            end
        end
    end

    // R6: a matching snoop on a valid line leaves it invalid
    a_r6_snoop_drops_line: assert property (@(posedge clk) disable iff (rst)
        (snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag) &&
         !(set_en && (set_idx == snp_idx)))
        |=> !valid_q[$past(snp_idx)]);

    // R9: reset empties the cache
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (valid_q == '0));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int                NC_BITS  = 2,
    parameter logic [NC_BITS-1:0] NC_VALUE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              clr_en,
    output logic              set_en
);
    addr_t             a;
    logic              noncache;
    logic              hit;
    logic              snoop_same;
    logic              last_word;
    state_e            state_q, state_d;
    logic [OFF_W-1:0]  cnt_q;
    logic              kill_q;
    logic [DATA_W-1:0] resp_q;

    assign a          = split_addr(cpu_addr);
    assign noncache   = (cpu_addr[ADDR_W-1 -: NC_BITS] == NC_VALUE);
    assign hit        = rd_valid && (rd_tag == a.tag) && !noncache;
    assign snoop_same = snoop_valid && (block_of(snoop_addr) == block_of(cpu_addr));
    assign last_word  = &cnt_q;

    always_comb begin
        state_d   = state_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        wr_en     = 1'b0;
        wr_off    = a.off;
        wr_data   = cpu_wdata;
        clr_en    = 1'b0;
        set_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we || noncache) begin
                        state_d = ST_SINGLE;
                    end else if (!hit) begin
                        state_d = ST_FILL;
                        clr_en  = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {a.tag, a.idx, cnt_q};
                wr_off   = cnt_q;
                wr_data  = mem_rdata;
                if (mem_ack) begin
                    wr_en = 1'b1;
                    if (last_word) begin
                        set_en  = !(kill_q || snoop_same);
                        state_d = ST_DONE;
                    end
                end
            end
            ST_SINGLE: begin
                mem_req = 1'b1;
                mem_we  = cpu_we;
                if (mem_ack) begin
                    wr_en   = cpu_we && hit;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kill_q  <= 1'b0;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q  <= '0;
                kill_q <= 1'b0;
            end
            if (state_q == ST_FILL) begin
                if (snoop_same) begin
                    kill_q <= 1'b1;
                end
                if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == a.off) begin
                        resp_q <= mem_rdata;
                    end
                end
            end
            if ((state_q == ST_SINGLE) && mem_ack && !cpu_we) begin
                resp_q <= mem_rdata;
            end
        end
    end

    assign cpu_rdata = (state_q == ST_DONE) ? resp_q : rd_byte;
    assign cpu_stall = cpu_req && (state_q != ST_DONE) &&
                       !((state_q == ST_IDLE) && !cpu_we && hit);

    // R10: handshake outputs hold until acknowledged
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: a write request puts a memory write on the port next cycle
    a_r4_write_to_mem: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && cpu_req && cpu_we) |=> (mem_req && mem_we));

    // R2: a fill only ever reads memory
    a_r2_fill_reads: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> !mem_we);

    // R8: noncacheable addresses never validate a line
    a_r8_nc_never_set: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !noncache);

    // R1: an access finishing from idle never used memory
    a_r1_hit_no_mem: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_stall && (state_q == ST_IDLE)) |-> !mem_req);
endmodule

// File: rtl/dmc_snoop_wt_cache.sv
module dmc_snoop_wt_cache
    import dmc_pkg::*;
#(
    parameter int                NC_BITS  = 2,
    parameter logic [NC_BITS-1:0] NC_VALUE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    addr_t             cpu_f, snp_f;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_byte;
    logic              wr_en, clr_en, set_en;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;

    assign cpu_f = split_addr(cpu_addr);
    assign snp_f = split_addr(snoop_addr);

    dmc_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cpu_f.idx),
        .rd_off   (cpu_f.off),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_byte  (rd_byte),
        .wr_en    (wr_en),
        .wr_idx   (cpu_f.idx),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .clr_en   (clr_en),
        .clr_idx  (cpu_f.idx),
        .set_en   (set_en),
        .set_idx  (cpu_f.idx),
        .set_tag  (cpu_f.tag),
        .snp_en   (snoop_valid),
        .snp_idx  (snp_f.idx),
        .snp_tag  (snp_f.tag)
    );

    dmc_ctrl #(
        .NC_BITS  (NC_BITS),
        .NC_VALUE (NC_VALUE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .cpu_stall   (cpu_stall),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_tag),
        .rd_byte     (rd_byte),
        .wr_en       (wr_en),
        .wr_off      (wr_off),
        .wr_data     (wr_data),
        .clr_en      (clr_en),
        .set_en      (set_en)
    );
endmodule

// File: tb/dmc_snoop_wt_cache_test.sv
`timescale 1ns/1ps
module dmc_snoop_wt_cache_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_stall;
    logic       mem_req, mem_we;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       mem_ack = 1'b0;
    logic       snoop_valid = 1'b0;
    logic [5:0] snoop_addr = '0;

    logic       ext_we = 1'b0;
    logic [5:0] ext_addr = '0;
    logic [7:0] ext_data = '0;

    int checks = 0;
    int failures = 0;
    int mem_ops = 0;
    logic [5:0] rlog [4];
    logic [7:0] mem [64];
    logic [7:0] refm [64];

    always #2.5 clk = ~clk;

    dmc_snoop_wt_cache uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    // memory model: one-cycle acknowledge, plus a port for the other master
    always @(posedge clk) begin
        if (ext_we) begin
            mem[ext_addr] <= ext_data;
        end
        if (rst) begin
            mem_ack <= 1'b0;
            if (!ext_we && mem_ops < 0) mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr];
                rlog[0] <= rlog[1];
                rlog[1] <= rlog[2];
                rlog[2] <= rlog[3];
                rlog[3] <= mem_addr;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (!rst && mem_req && mem_ack) begin
            mem_ops <= mem_ops + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [5:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output int ops);
        int start;
        @(negedge clk);
        start = mem_ops;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        forever begin
            #1;
            if (!cpu_stall) begin
                rd = cpu_rdata;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
        ops = mem_ops - start;
    endtask

    task automatic snoop_pulse(input logic [5:0] addr);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = addr;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic other_write(input logic [5:0] addr, input logic [7:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_addr = addr; ext_data = d;
        snoop_valid = 1'b1; snoop_addr = addr;
        refm[addr] = d;
        @(negedge clk);
        ext_we = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] addr, input int exp_ops, input string req);
        logic [7:0] d;
        int ops;
        access(1'b0, addr, 8'h00, d, ops);
        chk(ops == exp_ops, req, ops, exp_ops);
        chk(d == refm[addr], req, d, refm[addr]);
    endtask

    typedef struct packed {
        logic       we;
        logic [5:0] addr;
        logic [7:0] wd;
        logic [3:0] ops;
    } vec_t;
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h05, 8'h00, 4'd4},   // R2 miss fill
        '{1'b0, 6'h06, 8'h00, 4'd0},   // R1 hit
        '{1'b0, 6'h15, 8'h00, 4'd4},   // R3 conflict
        '{1'b0, 6'h05, 8'h00, 4'd4},   // R3 back again
        '{1'b1, 6'h06, 8'hAA, 4'd1},   // R4 write hit
        '{1'b0, 6'h06, 8'h00, 4'd0},   // R4 reads new value
        '{1'b1, 6'h29, 8'h55, 4'd1},   // R5 write miss
        '{1'b0, 6'h29, 8'h00, 4'd4},   // R5 no allocate
        '{1'b0, 6'h2A, 8'h00, 4'd0},   // R1 hit after fill
        '{1'b0, 6'h31, 8'h00, 4'd1},   // R8 uncached read
        '{1'b0, 6'h31, 8'h00, 4'd1},   // R8 again single
        '{1'b1, 6'h32, 8'h77, 4'd1},   // R8 uncached write
        '{1'b0, 6'h32, 8'h00, 4'd1},   // R8 reads written value
        '{1'b0, 6'h3C, 8'h00, 4'd1}    // R8 top of region
    };
    localparam string VTAG [NV] = '{"R2", "R1", "R3", "R3", "R4", "R4", "R5",
                                     "R5", "R1", "R8", "R8", "R8", "R8", "R8"};

    bit done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int ops;
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9: idle outputs out of reset
        chk(cpu_stall == 1'b0, "R9", cpu_stall, 0);
        chk(mem_req == 1'b0, "R9", mem_req, 0);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v].we, VEC[v].addr, VEC[v].wd, d, ops);
            chk(ops == int'(VEC[v].ops), VTAG[v], ops, VEC[v].ops);
            if (VEC[v].we) begin
                refm[VEC[v].addr] = VEC[v].wd;
                chk(mem[VEC[v].addr] == VEC[v].wd, "R4", mem[VEC[v].addr], VEC[v].wd);
            end else begin
                chk(d == refm[VEC[v].addr], VTAG[v], d, refm[VEC[v].addr]);
            end
            if (VEC[v].ops == 4'd4) begin
                // R2: fill order offsets 0..3 of the block
                for (int k = 0; k < 4; k++) begin
                    chk(rlog[k] == {VEC[v].addr[5:2], 2'(k)}, "R2", rlog[k],
                        {VEC[v].addr[5:2], 2'(k)});
                end
            end
        end

        // R6: snoop on a different tag leaves the resident line
        rd_chk(6'h05, 0, "R6");
        snoop_pulse(6'h15);
        rd_chk(6'h05, 0, "R6");
        // R6: other master writes inside the block -> line dropped, fresh data
        other_write(6'h07, 8'hC3);
        other_write(6'h05, 8'h99);
        rd_chk(6'h05, 4, "R6");
        rd_chk(6'h07, 0, "R6");

        // R7: snoop lands in the middle of a fill of the same block
        fork
            rd_chk(6'h09, 4, "R7");
            begin
                repeat (4) @(negedge clk);
                snoop_addr = 6'h0A;
                snoop_valid = 1'b1;
                @(negedge clk);
                snoop_valid = 1'b0;
            end
        join
        rd_chk(6'h09, 4, "R7");
        rd_chk(6'h0A, 0, "R7");

        // R9: reset in the middle of life empties the cache
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk(6'h0A, 4, "R9");
        rd_chk(6'h2A, 4, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule